// File: doc/BRIEF.md
# Serial Mode-Register Programming Slave

This block lets an external host program a small bank of 8-bit mode-control registers over a four-wire serial link. The wires are an active-low select, a serial clock, a data input and an open-drain data output. The rest of the chip sees the register contents as a flat vector, `regs_o`. A transaction opens when the select falls and closes when it rises. Each transaction carries one 16-bit frame, sent most significant bit first. The first bit is a direction flag: 0 means write and 1 means read. The next seven bits are the register address, A6 first. The last eight bits are data, D7 first.

The serial pins are brought into the block's own clock domain through a multi-stage synchronizer. Serial clock edges are then detected in that domain. For this reason the serial clock must stay well below the block clock. Each serial clock phase must last longer than the synchronizer depth plus two block clocks.

A read does not modify the addressed register. The register's contents are presented on the data output, and the host samples them on the last eight rising serial clock edges. The data output can only pull low or release the line, so a logic 1 comes from an external pull-up.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset every register holds 0x00 and `sdo_oe_o` is 0, so the line is released.
- R2: A complete frame whose first bit is 0 writes its last eight bits to the register named by bits 2 to 8. The new value appears on `regs_o` byte `addr`, at bits `[8*addr+7:8*addr]`, before the select rises.
- R3: A frame whose first bit is 1 presents the addressed register on the data line during bits 9 to 16, D7 first. The value changes after each falling serial clock edge, so it is valid at the following rising edge. The register is not modified, and the data-in bits are ignored.
- R4: Rising serial clock edges after the sixteenth in a transaction have no effect on any register.
- R5: A transaction closed by the select rising before the sixteenth rising edge changes no register.
- R6: A write to an address at or above `NUM_REGS` changes no register. A read from such an address returns 0x00.
- R7: Whenever the synchronized select is high, the data line is released (`sdo_oe_o` = 0). Setting `sdo_oe_o` to 1 means the line is pulled low, and a logic 1 is never driven.
- R8: During the first eight bits of any frame the data line stays released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Active-low transaction select |
| sck_i | input | 1 | Serial clock from host |
| sdi_i | input | 1 | Serial data from host |
| sdo_oe_o | output | 1 | 1 = pull data line low, 0 = release |
| regs_o | output | NUM_REGS*8 | Register contents, register n at bits [8n+7:8n] |

## Verification
The bench builds the block with `NUM_REGS` = 6 and a two-stage synchronizer. It draws addresses from 0 to 7, so writes and reads to the two unimplemented addresses occur alongside writes and reads to the real ones. The short synchronizer allows a serial half-period of eight block clocks while still meeting the edge-detection margin. The bench therefore covers frames of every length, from aborted after a few bits, through exactly sixteen bits, to frames followed by extra clock edges, all in a few thousand cycles per scenario.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;
  localparam int ADDR_W     = 7;
  localparam int DATA_W     = 8;
  localparam int HDR_BITS   = 1 + ADDR_W;
  localparam int FRAME_BITS = HDR_BITS + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int SEL_W      = $clog2(DATA_W);

  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [CNT_W-1:0]  cnt_t;
endpackage

// File: rtl/spi_regs_sync.sv
module spi_regs_sync #(
  parameter int                WIDTH   = 3,
  parameter int                STAGES  = 2,
  parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] pipe_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  pipe_q[s] <= RST_VAL;
      else if (s == 0) pipe_q[s] <= d_i;
      else          pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/spi_regs_frame.sv
module spi_regs_frame
  import spi_regs_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cs_s_i,
  input  logic  sck_s_i,
  input  logic  sdi_s_i,
  input  byte_t rd_data_i,
  output addr_t addr_o,
  output logic  wr_en_o,
  output byte_t wr_data_o,
  output cnt_t  bit_cnt_o,
  output logic  sdo_oe_o
);
  logic                sck_q;
  logic                sck_rise, sck_fall;
  cnt_t                cnt_q;
  logic [DATA_W-2:0]   shift_q;
  logic                rw_q;
  addr_t               addr_q;
  logic                pull_q;
  logic [SEL_W-1:0]    bit_sel;
  logic                hdr_done, frame_last, in_data;

  assign sck_rise   = sck_s_i & ~sck_q;
  assign sck_fall   = ~sck_s_i & sck_q;
  assign hdr_done   = (cnt_q == cnt_t'(HDR_BITS - 1));
  assign frame_last = (cnt_q == cnt_t'(FRAME_BITS - 1));
  assign in_data    = (cnt_q >= cnt_t'(HDR_BITS)) && (cnt_q < cnt_t'(FRAME_BITS));
  // D7 is selected at count HDR_BITS, D0 at FRAME_BITS-1
  assign bit_sel    = SEL_W'(cnt_t'(FRAME_BITS - 1) - cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_s_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      shift_q <= '0;
      rw_q    <= 1'b0;
      addr_q  <= '0;
      pull_q  <= 1'b0;
    end else if (cs_s_i) begin
      cnt_q   <= '0;
      rw_q    <= 1'b0;
      pull_q  <= 1'b0;
    end else begin
      if (sck_rise && cnt_q != cnt_t'(FRAME_BITS)) begin
        shift_q <= {shift_q[DATA_W-3:0], sdi_s_i};
        cnt_q   <= cnt_q + cnt_t'(1);
        if (hdr_done) begin
          rw_q   <= shift_q[DATA_W-2];
          addr_q <= {shift_q[ADDR_W-2:0], sdi_s_i};
        end
      end
      if (sck_fall) begin
        if (in_data && rw_q) pull_q <= ~rd_data_i[bit_sel];
        else                 pull_q <= 1'b0;
      end
    end
  end

  assign wr_en_o   = !cs_s_i && sck_rise && frame_last && !rw_q;
  assign wr_data_o = {shift_q, sdi_s_i};
  assign addr_o    = addr_q;
  assign bit_cnt_o = cnt_q;
  assign sdo_oe_o  = pull_q;
endmodule

// File: rtl/spi_regs_bank.sv
module spi_regs_bank
  import spi_regs_pkg::*;
#(
  parameter int    NUM_REGS = 4,
  parameter byte_t RST_VAL  = '0
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  addr_t                      addr_i,
  input  byte_t                      wr_data_i,
  output byte_t                      rd_data_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  byte_t regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 regs_q[g] <= RST_VAL;
      else if (wr_en_i && addr_i == addr_t'(g))    regs_q[g] <= wr_data_i;
    end
    assign regs_o[g*DATA_W +: DATA_W] = regs_q[g];
  end

  // unimplemented addresses read as zero
  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (addr_i == addr_t'(i)) rd_data_o = regs_q[i];
    end
  end
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_regs_pkg::*;
#(
  parameter int    NUM_REGS    = 4,
  parameter int    SYNC_STAGES = 2,
  parameter byte_t RST_VAL     = '0
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cs_ni,
  input  logic                       sck_i,
  input  logic                       sdi_i,
  output logic                       sdo_oe_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  logic  cs_s, sck_s, sdi_s;
  addr_t wr_addr;
  logic  wr_en;
  byte_t wr_data, rd_data;
  cnt_t  bit_cnt;

  spi_regs_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b001)
  ) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sdi_i, sck_i, cs_ni}),
    .q_o   ({sdi_s, sck_s, cs_s})
  );

  spi_regs_frame frame_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_s_i   (cs_s),
    .sck_s_i  (sck_s),
    .sdi_s_i  (sdi_s),
    .rd_data_i(rd_data),
    .addr_o   (wr_addr),
    .wr_en_o  (wr_en),
    .wr_data_o(wr_data),
    .bit_cnt_o(bit_cnt),
    .sdo_oe_o (sdo_oe_o)
  );

  spi_regs_bank #(
    .NUM_REGS(NUM_REGS),
    .RST_VAL (RST_VAL)
  ) bank_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .addr_i   (wr_addr),
    .wr_data_i(wr_data),
    .rd_data_o(rd_data),
    .regs_o   (regs_o)
  );
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk
  import spi_regs_pkg::*;
#(
  parameter int NUM_REGS = 4
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       cs_s,
  input cnt_t                       bit_cnt,
  input logic                       wr_en,
  input addr_t                      wr_addr,
  input logic                       sdo_oe_o,
  input logic [NUM_REGS*DATA_W-1:0] regs_o
);
  // R2
  regs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> $stable(regs_o));

  // R6
  oob_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && wr_addr >= addr_t'(NUM_REGS)) |=> $stable(regs_o));

  // R4
  cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_cnt == cnt_t'(FRAME_BITS)) |=> (bit_cnt == cnt_t'(FRAME_BITS) || bit_cnt == '0));

  // R7
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> !sdo_oe_o);

  // R8
  hdr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_cnt < cnt_t'(HDR_BITS)) |-> !sdo_oe_o);
endmodule

bind spi_reg_slave spi_reg_slave_chk #(.NUM_REGS(NUM_REGS)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_s    (cs_s),
  .bit_cnt (bit_cnt),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .sdo_oe_o(sdo_oe_o),
  .regs_o  (regs_o)
);

// File: tb/spi_reg_slave_tb.sv
module spi_reg_slave_tb_top;
  localparam int NR = 6;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic sdo_oe;
  logic [NR*8-1:0] regs;

  int n_chk = 0, n_fail = 0;
  logic [7:0] mdl [NR];

  always #5 clk = ~clk;

  spi_reg_slave #(.NUM_REGS(NR), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .sdi_i(sdi),
    .sdo_oe_o(sdo_oe), .regs_o(regs)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hw();
    repeat (HALF) @(negedge clk);
  endtask

  function automatic logic [NR*8-1:0] exp_regs();
    logic [NR*8-1:0] v;
    for (int i = 0; i < NR; i++) v[i*8 +: 8] = mdl[i];
    return v;
  endfunction

  function automatic logic [7:0] exp_read(input logic [6:0] a);
    return (a < 7'(NR)) ? mdl[a] : 8'h00;
  endfunction

  task automatic frame(input bit rw, input logic [6:0] a, input logic [7:0] d,
                       input int nbits, input int extra,
                       output logic [7:0] rb, output bit hdr_quiet);
    logic [15:0] w;
    w = {rw, a, d};
    rb = '0;
    hdr_quiet = 1'b1;
    @(negedge clk);
    cs_n = 1'b0;
    hw();
    for (int i = 0; i < nbits; i++) begin
      sdi = w[15-i];
      hw();
      if (i >= 8) rb[15-i] = ~sdo_oe;
      else if (sdo_oe) hdr_quiet = 1'b0;
      sck = 1'b1;
      hw();
      sck = 1'b0;
    end
    for (int i = 0; i < extra; i++) begin
      sdi = 1'($urandom);
      hw();
      sck = 1'b1;
      hw();
      sck = 1'b0;
    end
    hw();
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
    if (!rw && nbits >= 16 && a < 7'(NR)) mdl[a] = d;
  endtask

  task automatic post(input string req);
    chk(regs == exp_regs(), req, 64'(regs), 64'(exp_regs()));
    chk(sdo_oe == 1'b0, "R7", 64'(sdo_oe), 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hang expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    logic [7:0] rb, ex;
    bit hq;
    void'($urandom(32'd1234));
    for (int i = 0; i < NR; i++) mdl[i] = 8'h00;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(regs == '0, "R1 regs", 64'(regs), 64'd0);
    chk(sdo_oe == 1'b0, "R1 sdo", 64'(sdo_oe), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 write every implemented register
    for (int i = 0; i < NR; i++) begin
      frame(1'b0, 7'(i), 8'(8'h5A ^ (i * 37)), 16, 0, rb, hq);
      post("R2");
    end
    // R3 read each back with junk data bits, R8 header quiet
    for (int i = 0; i < NR; i++) begin
      ex = exp_read(7'(i));
      frame(1'b1, 7'(i), 8'($urandom), 16, 0, rb, hq);
      chk(rb == ex, "R3 read", 64'(rb), 64'(ex));
      chk(hq, "R8", 64'(!hq), 64'd0);
      post("R3 unchanged");
    end
    // R3 all-ones / all-zeros patterns
    frame(1'b0, 7'd2, 8'hFF, 16, 0, rb, hq);
    frame(1'b1, 7'd2, 8'h00, 16, 0, rb, hq);
    chk(rb == 8'hFF, "R3 ones", 64'(rb), 64'hFF);
    frame(1'b0, 7'd3, 8'h00, 16, 0, rb, hq);
    frame(1'b1, 7'd3, 8'hFF, 16, 0, rb, hq);
    chk(rb == 8'h00, "R3 zeros", 64'(rb), 64'h00);
    post("R3");
    // R6 unimplemented address
    frame(1'b0, 7'h7F, 8'hC3, 16, 0, rb, hq);
    post("R6 write");
    frame(1'b1, 7'h7F, 8'h00, 16, 0, rb, hq);
    chk(rb == 8'h00, "R6 read", 64'(rb), 64'h00);
    frame(1'b0, 7'(NR), 8'h99, 16, 0, rb, hq);
    post("R6 edge addr");
    // R4 extra edges after sixteenth
    frame(1'b0, 7'd1, 8'hA5, 16, 9, rb, hq);
    post("R4 write+extra");
    frame(1'b1, 7'd1, 8'h00, 16, 6, rb, hq);
    chk(rb == 8'hA5, "R4 read+extra", 64'(rb), 64'hA5);
    post("R4");
    // R5 aborted frames
    frame(1'b0, 7'd0, 8'h3C, 15, 0, rb, hq);
    post("R5 15 bits");
    frame(1'b0, 7'd4, 8'h3C, 5, 0, rb, hq);
    post("R5 5 bits");
    frame(1'b0, 7'd5, 8'h3C, 8, 0, rb, hq);
    post("R5 8 bits");

    // random mix
    for (int k = 0; k < 40; k++) begin
      bit rw;
      logic [6:0] a;
      int nb, ext;
      rw  = 1'($urandom);
      a   = 7'($urandom_range(0, 7));
      nb  = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 15)) : 16;
      ext = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 4)) : 0;
      ex  = exp_read(a);
      frame(rw, a, 8'($urandom), nb, ext, rb, hq);
      if (rw && nb == 16) chk(rb == ex, "R3 random read", 64'(rb), 64'(ex));
      if (rw) chk(hq, "R8 random", 64'(!hq), 64'd0);
      post("R2 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule